// File: doc/BRIEF.md
# Register-Immediate Arithmetic Execute Unit

This block executes one 24-bit instruction word at a time against a private bank of eight 32-bit general registers. Each word holds a 5-bit operation code in bits [23:19], a 3-bit destination/source register index in bits [18:16] and a 16-bit trailing field in bits [15:0]. The trailing field is either a signed literal or a second register index. Move, add, subtract, multiply and divide each come in a register-register form and a register-literal form.

An instruction is presented with a valid flag and is taken on a clock edge where the unit is ready. Move, add and subtract finish on the edge that takes them. Multiply and divide hold the unit busy and refuse new work until they finish. A combinational read port exposes any register. Two free-running counters report elapsed clock cycles and completed instructions, so a bench can derive cycles per instruction.

Top module: `arith_exec_unit`

## Requirements
- R1: After reset, all eight registers, the cycle counter, the completed counter and div_err_o are zero, busy_o is low and instr_ready_o is high.
- R2: Opcode 1 (move literal) writes the 16-bit field, sign-extended to 32 bits, into the register named by bits [18:16] (call it rA).
- R3: Opcode 0 (move register) copies rA into the register named by field bits [2:0] (rB), and rA stays unchanged.
- R4: Opcodes 2/3 write rA + operand and opcodes 4/5 write rA - operand into rA, wrapping modulo 2^32. An even opcode takes the operand from rB; an odd opcode takes the sign-extended field.
- R5: Opcodes 6/7 write the low 32 bits of the signed product of rA and the operand into rA. busy_o is high for the 2 cycles after acceptance, and the result is written on the second edge after acceptance.
- R6: Opcodes 8/9 write the signed quotient of rA divided by the operand, truncated toward zero, into rA. busy_o is high for the 15 cycles after acceptance, and the result is written on the 15th edge after acceptance. 0x80000000 divided by -1 gives 0x80000000.
- R7: A divide by zero leaves rA unchanged and sets div_err_o, which stays high until reset. The instruction still takes the full divide time and still counts as completed.
- R8: Opcodes 10 to 31 change no register and count as completed on the edge that takes them.
- R9: instr_ready_o equals the inverse of busy_o. A valid instruction offered while busy is not taken and has no effect until the unit becomes ready.
- R10: cycle_cnt_o increments on every clock edge out of reset. retired_cnt_o increments once per instruction, on the edge where its result is written (or, for opcodes 10 to 31 and divide by zero, where it completes).
- R11: In register forms only field bits [2:0] select rB; field bits [15:3] have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| instr_valid_i | input | 1 | Instruction word is offered |
| instr_i | input | 24 | Instruction word |
| instr_ready_o | output | 1 | Unit can take an instruction this cycle |
| busy_o | output | 1 | Multiply or divide in flight |
| rd_addr_i | input | 3 | Read-back register index |
| rd_data_o | output | 32 | Read-back register value (combinational) |
| div_err_o | output | 1 | Sticky divide-by-zero flag |
| cycle_cnt_o | output | 32 | Clock cycles since reset |
| retired_cnt_o | output | 32 | Instructions completed since reset |

## Verification
Directed words exercise each operation in both operand forms. Negative literals show whether sign extension happens. A register form with junk in the upper field bits shows whether only the low index bits are decoded. Register moves in both directions show which operand the move writes. Divides with mixed signs, the most-negative-by-minus-one case and a zero divisor separate truncation toward zero from floor rounding, and a skipped write from a garbage one. A long run of random words with random offer gaps, mixing every opcode including the unused ones, shows whether the busy window, back-pressure and both counters follow the stated latencies cycle by cycle.

// File: rtl/arith_pkg.sv
package arith_pkg;
  localparam int OPC_W = 5;

  typedef enum logic [3:0] {
    KIND_MOV = 4'd0,
    KIND_ADD = 4'd1,
    KIND_SUB = 4'd2,
    KIND_MUL = 4'd3,
    KIND_DIV = 4'd4
  } op_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_MUL  = 2'd1,
    ST_DIV  = 2'd2
  } exec_state_e;
endpackage

// File: rtl/arith_regfile.sv
module arith_regfile #(
  parameter int DATA_W = 32,
  parameter int RIDX_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [RIDX_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [RIDX_W-1:0] raddr_a_i,
  output logic [DATA_W-1:0] rdata_a_o,
  input  logic [RIDX_W-1:0] raddr_b_i,
  output logic [DATA_W-1:0] rdata_b_o,
  input  logic [RIDX_W-1:0] raddr_c_i,
  output logic [DATA_W-1:0] rdata_c_o
);
  localparam int NREGS = 1 << RIDX_W;

  logic [DATA_W-1:0] regs_q [NREGS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NREGS; i++) regs_q[i] <= '0;
    end else if (we_i) begin
      regs_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_a_o = regs_q[raddr_a_i];
  assign rdata_b_o = regs_q[raddr_b_i];
  assign rdata_c_o = regs_q[raddr_c_i];

  AST_WADDR_KNOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |-> !$isunknown(waddr_i)); // R3
endmodule

// File: rtl/arith_divider.sv
module arith_divider #(
  parameter int DATA_W = 32,
  parameter int ITERS  = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] dividend_i,
  input  logic [DATA_W-1:0] divisor_i,
  input  logic              step_i,
  output logic [DATA_W-1:0] quot_o
);
  // bits resolved per clock; dividend is zero-padded to EXT_W so the
  // iteration count always divides evenly
  localparam int SPC   = (DATA_W + ITERS - 1) / ITERS;
  localparam int EXT_W = SPC * ITERS;

  logic [EXT_W-1:0]  q_q, q_n;
  logic [DATA_W:0]   r_q, r_n;
  logic [DATA_W-1:0] d_q;
  logic              neg_q;

  wire [DATA_W-1:0] mag_a = dividend_i[DATA_W-1] ? -dividend_i : dividend_i;
  wire [DATA_W-1:0] mag_b = divisor_i[DATA_W-1]  ? -divisor_i  : divisor_i;

  always_comb begin
    q_n = q_q;
    r_n = r_q;
    for (int s = 0; s < SPC; s++) begin
      r_n = {r_n[DATA_W-1:0], q_n[EXT_W-1]};
      q_n = {q_n[EXT_W-2:0], 1'b0};
      if (r_n >= {1'b0, d_q}) begin
        r_n    = r_n - {1'b0, d_q};
        q_n[0] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_q   <= '0;
      r_q   <= '0;
      d_q   <= '0;
      neg_q <= 1'b0;
    end else if (load_i) begin
      q_q   <= EXT_W'(mag_a);
      r_q   <= '0;
      d_q   <= mag_b;
      neg_q <= dividend_i[DATA_W-1] ^ divisor_i[DATA_W-1];
    end else if (step_i) begin
      q_q <= q_n;
      r_q <= r_n;
    end
  end

  assign quot_o = neg_q ? -q_n[DATA_W-1:0] : q_n[DATA_W-1:0];

  AST_DIV_REM_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (d_q != '0) |-> (r_q < {1'b0, d_q})); // R6
endmodule

// File: rtl/arith_perf.sv
module arith_perf #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             retire_i,
  output logic [CNT_W-1:0] cycles_o,
  output logic [CNT_W-1:0] retired_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cycles_o  <= '0;
      retired_o <= '0;
    end else begin
      cycles_o <= cycles_o + 1'b1;
      if (retire_i) retired_o <= retired_o + 1'b1;
    end
  end

  AST_RETIRE_LE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retired_o <= cycles_o); // R10
endmodule

// File: rtl/arith_exec_unit.sv
module arith_exec_unit
  import arith_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int FIELD_W = 16,
  parameter int RIDX_W  = 3,
  parameter int MUL_LAT = 3,
  parameter int DIV_LAT = 16,
  parameter int CNT_W   = 32
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              instr_valid_i,
  input  logic [OPC_W+RIDX_W+FIELD_W-1:0]   instr_i,
  output logic                              instr_ready_o,
  output logic                              busy_o,
  input  logic [RIDX_W-1:0]                 rd_addr_i,
  output logic [DATA_W-1:0]                 rd_data_o,
  output logic                              div_err_o,
  output logic [CNT_W-1:0]                  cycle_cnt_o,
  output logic [CNT_W-1:0]                  retired_cnt_o
);
  localparam int INSTR_W = OPC_W + RIDX_W + FIELD_W;
  localparam int MAX_LAT = (DIV_LAT > MUL_LAT) ? DIV_LAT : MUL_LAT;
  localparam int BCNT_W  = $clog2(MAX_LAT + 1);

  // decode
  wire [OPC_W-1:0]  opc      = instr_i[INSTR_W-1 -: OPC_W];
  wire [3:0]        kind     = opc[OPC_W-1:1];
  wire              imm_sel  = opc[0];
  wire [RIDX_W-1:0] ra_idx   = instr_i[FIELD_W +: RIDX_W];
  wire [FIELD_W-1:0] field   = instr_i[FIELD_W-1:0];
  wire [RIDX_W-1:0] rb_idx   = field[RIDX_W-1:0];
  wire [DATA_W-1:0] imm_ext  = {{(DATA_W-FIELD_W){field[FIELD_W-1]}}, field};

  logic [DATA_W-1:0] ra_data, rb_data, opb;
  logic              rf_we, retire, div_zero_fin;
  logic [RIDX_W-1:0] rf_waddr;
  logic [DATA_W-1:0] rf_wdata, div_quot;

  exec_state_e       st_q;
  logic [BCNT_W-1:0] cnt_q;
  logic [RIDX_W-1:0] dst_q;
  logic [DATA_W-1:0] mul_a_q, mul_b_q;
  logic              div_zero_q;

  assign busy_o        = (cnt_q != '0);
  assign instr_ready_o = !busy_o;
  assign opb           = imm_sel ? imm_ext : rb_data;

  wire accept    = instr_valid_i && instr_ready_o;
  wire finishing = (cnt_q == BCNT_W'(1));
  wire [DATA_W-1:0] product = mul_a_q * mul_b_q;

  arith_regfile #(.DATA_W(DATA_W), .RIDX_W(RIDX_W)) u_rf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (rf_we),
    .waddr_i   (rf_waddr),
    .wdata_i   (rf_wdata),
    .raddr_a_i (ra_idx),
    .rdata_a_o (ra_data),
    .raddr_b_i (rb_idx),
    .rdata_b_o (rb_data),
    .raddr_c_i (rd_addr_i),
    .rdata_c_o (rd_data_o)
  );

  arith_divider #(.DATA_W(DATA_W), .ITERS(DIV_LAT-1)) u_div (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (accept && kind == KIND_DIV),
    .dividend_i (ra_data),
    .divisor_i  (opb),
    .step_i     (st_q == ST_DIV && busy_o),
    .quot_o     (div_quot)
  );

  arith_perf #(.CNT_W(CNT_W)) u_perf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .retire_i  (retire),
    .cycles_o  (cycle_cnt_o),
    .retired_o (retired_cnt_o)
  );

  always_comb begin
    rf_we        = 1'b0;
    rf_waddr     = ra_idx;
    rf_wdata     = '0;
    retire       = 1'b0;
    div_zero_fin = 1'b0;
    if (finishing) begin
      retire   = 1'b1;
      rf_waddr = dst_q;
      if (st_q == ST_MUL) begin
        rf_we    = 1'b1;
        rf_wdata = product;
      end else if (div_zero_q) begin
        div_zero_fin = 1'b1;
      end else begin
        rf_we    = 1'b1;
        rf_wdata = div_quot;
      end
    end else if (accept) begin
      case (kind)
        KIND_MOV: begin
          rf_we  = 1'b1;
          retire = 1'b1;
          if (imm_sel) rf_wdata = imm_ext;
          else begin
            rf_waddr = rb_idx;  // register move targets the second index
            rf_wdata = ra_data;
          end
        end
        KIND_ADD: begin rf_we = 1'b1; retire = 1'b1; rf_wdata = ra_data + opb; end
        KIND_SUB: begin rf_we = 1'b1; retire = 1'b1; rf_wdata = ra_data - opb; end
        KIND_MUL, KIND_DIV: ;
        default: retire = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      cnt_q      <= '0;
      dst_q      <= '0;
      mul_a_q    <= '0;
      mul_b_q    <= '0;
      div_zero_q <= 1'b0;
      div_err_o  <= 1'b0;
    end else begin
      if (div_zero_fin) div_err_o <= 1'b1;
      if (accept && kind == KIND_MUL) begin
        st_q    <= ST_MUL;
        cnt_q   <= BCNT_W'(MUL_LAT - 1);
        dst_q   <= ra_idx;
        mul_a_q <= ra_data;
        mul_b_q <= opb;
      end else if (accept && kind == KIND_DIV) begin
        st_q       <= ST_DIV;
        cnt_q      <= BCNT_W'(DIV_LAT - 1);
        dst_q      <= ra_idx;
        div_zero_q <= (opb == '0);
      end else if (busy_o) begin
        cnt_q <= cnt_q - 1'b1;
        if (finishing) st_q <= ST_IDLE;
      end
    end
  end

  AST_NO_WRITE_MIDFLIGHT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q > BCNT_W'(1)) |-> !rf_we); // R9
  AST_BUSY_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    finishing |=> !busy_o); // R5
  AST_IDLE_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE) |-> instr_ready_o); // R9
  AST_DIVERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_err_o |=> div_err_o); // R7
endmodule

// File: tb/tb_arith_exec_unit.sv
module tb_arith_exec_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [23:0] instr = '0;
  logic [2:0]  rd_addr = '0;
  logic        ready, busy, derr;
  logic [31:0] rd_data, cyc, ret;

  int unsigned nvec = 0, nfail = 0;
  string       cur_req = "R1";

  always #10 clk = ~clk;  // 50 MHz

  arith_exec_unit dut (
    .clk_i(clk), .rst_ni(rst_n), .instr_valid_i(valid), .instr_i(instr),
    .instr_ready_o(ready), .busy_o(busy), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .div_err_o(derr), .cycle_cnt_o(cyc), .retired_cnt_o(ret)
  );

  // behavioural reference
  logic [31:0] m_reg [8] = '{default: 32'd0};
  int unsigned m_cyc = 0, m_ret = 0;
  int          m_busy = 0;
  bit          m_err = 0, m_acc = 0, p_zero = 0;
  int          p_dst = 0;
  logic [31:0] p_val = '0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (m_reg[i]) m_reg[i] = '0;
      m_cyc = 0; m_ret = 0; m_busy = 0; m_err = 0; m_acc = 0;
    end else begin
      m_acc = 0;
      m_cyc++;
      if (m_busy > 0) begin
        m_busy--;
        if (m_busy == 0) begin
          m_ret++;
          if (p_zero) m_err = 1; else m_reg[p_dst] = p_val;
        end
      end else if (valid) begin
        logic [4:0]  op;
        logic [2:0]  a, b;
        logic [31:0] iv, ov;
        longint      la, lb;
        m_acc = 1;
        op = instr[23:19]; a = instr[18:16]; b = instr[2:0];
        iv = {{16{instr[15]}}, instr[15:0]};
        ov = op[0] ? iv : m_reg[b];
        la = longint'($signed(m_reg[a]));
        lb = longint'($signed(ov));
        case (op >> 1)
          0: begin if (op[0]) m_reg[a] = iv; else m_reg[b] = m_reg[a]; m_ret++; end
          1: begin m_reg[a] = m_reg[a] + ov; m_ret++; end
          2: begin m_reg[a] = m_reg[a] - ov; m_ret++; end
          3: begin longint pr; pr = la * lb; p_val = pr[31:0]; p_dst = a; p_zero = 0; m_busy = 2; end
          4: begin
            longint qq;
            p_dst = a; p_zero = (ov == 0);
            if (!p_zero) begin qq = la / lb; p_val = qq[31:0]; end
            m_busy = 15;
          end
          default: m_ret++;
        endcase
      end
    end
  end

  task automatic cmp(string req, string what, logic [31:0] act, logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      #1;
      cmp(cur_req, "busy", 32'(busy), 32'(m_busy != 0));
      cmp((cur_req == "R1") ? "R1" : "R9", "ready", 32'(ready), 32'(m_busy == 0));
      cmp((cur_req == "R1") ? "R1" : "R7", "div_err", 32'(derr), 32'(m_err));
      cmp((cur_req == "R1") ? "R1" : "R10", "cycles", cyc, m_cyc);
      cmp((cur_req == "R1") ? "R1" : "R10", "retired", ret, m_ret);
      for (int i = 0; i < 8; i++) begin
        rd_addr = 3'(i);
        #1;
        cmp(cur_req, $sformatf("r%0d", i), rd_data, m_reg[i]);
      end
    end
  end

  function automatic logic [23:0] mk(int op, int a, int f);
    return {5'(op), 3'(a), 16'(f)};
  endfunction

  task automatic issue(logic [23:0] w);
    valid = 1'b1;
    instr = w;
    do @(negedge clk); while (!m_acc);
    valid = 1'b0;
  endtask

  task automatic drain();
    while (m_busy != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic peek(int idx, logic [31:0] exp, string req);
    @(posedge clk);
    #3 rd_addr = 3'(idx);
    #1 cmp(req, $sformatf("peek r%0d", idx), rd_data, exp);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    cur_req = "R2";
    issue(mk(1, 1, -6));           drain(); peek(1, 32'hFFFF_FFFA, "R2");
    cur_req = "R4";
    issue(mk(3, 1, 10));           drain(); peek(1, 32'd4, "R4");
    cur_req = "R3";
    issue(mk(0, 1, 3));            drain(); peek(3, 32'd4, "R3"); peek(1, 32'd4, "R3");
    cur_req = "R11";
    issue(mk(2, 3, 16'h1231));     drain(); peek(3, 32'd8, "R11");
    cur_req = "R4";
    issue(mk(5, 3, 5));            drain(); peek(3, 32'd3, "R4");
    issue(mk(4, 3, 1));            drain(); peek(3, 32'hFFFF_FFFF, "R4");

    cur_req = "R5";
    issue(mk(7, 1, -3));
    cur_req = "R9";
    issue(mk(1, 5, 7));            drain();
    peek(1, 32'hFFFF_FFF4, "R5"); peek(5, 32'd7, "R9");

    cur_req = "R6";
    issue(mk(9, 1, 5));            drain(); peek(1, 32'hFFFF_FFFE, "R6");
    issue(mk(1, 6, 7)); issue(mk(1, 7, -2));
    issue(mk(8, 6, 7));            drain(); peek(6, 32'hFFFF_FFFD, "R6");
    issue(mk(1, 2, -32768)); issue(mk(1, 4, 16384));
    issue(mk(6, 2, 4));            drain(); peek(2, 32'hE000_0000, "R5");
    issue(mk(1, 4, 4));
    issue(mk(6, 2, 4));            drain(); peek(2, 32'h8000_0000, "R5");
    issue(mk(1, 5, -1));
    issue(mk(8, 2, 5));            drain(); peek(2, 32'h8000_0000, "R6");

    cur_req = "R7";
    cmp("R7", "div_err before", 32'(derr), 32'd0);
    issue(mk(8, 1, 0));            drain();
    peek(1, 32'hFFFF_FFFE, "R7");
    cmp("R7", "div_err set", 32'(derr), 32'd1);

    cur_req = "R8";
    begin
      logic [31:0] r0;
      r0 = ret;
      issue(mk(10, 3, 16'h7FFF)); issue(mk(31, 4, 16'h8001)); drain();
      cmp("R8", "retired delta", ret - r0, 32'd2);
      peek(3, 32'hFFFF_FFFF, "R8"); peek(4, 32'd4, "R8");
    end

    cur_req = "R10";
    for (int n = 0; n < 600; n++) begin
      int op, f;
      op = $urandom_range(0, 31);
      f  = ($urandom_range(0, 3) == 0) ? int'($urandom_range(0, 65535))
                                       : $urandom_range(0, 40) - 20;
      repeat ($urandom_range(0, 2)) @(negedge clk);
      issue(mk(op, $urandom_range(0, 7), f));
    end
    drain();
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule